// File: doc/BRIEF.md
# Dual Instruction Prefetch Buffer Controller

This block sits between an instruction fetch stage and an instruction cache. It keeps two fetch buffers, each tracking one aligned block of instruction memory. For every fetch address it rounds the address down to the block size. It then finds the buffer that already tracks that block, falling back to buffer 0 when neither does. If the chosen buffer tracks some other block, the controller retargets it and raises a load request at the cache. The other buffer is kept pointed at the block right after the current one, so that straight-line code finds its next block already requested. The two buffers therefore alternate roles as execution walks forward.

Each request carries a tag from a shared counter and the number of the buffer it fills. A response retires a buffer only when both the buffer number and the tag match what that buffer is waiting for. The fetch stage is held until the current buffer has its data. A pending branch penalty is charged as extra hold cycles on the first fetch after it is loaded. When the instruction cache and cycle accounting are both switched off, the controller steps aside and does nothing.

Top module: `ifp_ctrl`

## Requirements
- R1: Every buffer address and every request address is the fetch address rounded down to a multiple of BLK_BYTES (default 16), so the low log2(BLK_BYTES) bits of `req_addr` are always zero.
- R2: The current buffer is the one whose held block equals the rounded fetch address, with buffer 0 preferred when both match. When no buffer holds it, buffer 0 becomes current.
- R3: When the current buffer does not hold the rounded address, it is retargeted to it and one request goes out with `req_slot` equal to that buffer's number (0 or 1).
- R4: The other buffer is the prefetch buffer and targets the rounded address plus BLK_BYTES. It is retargeted and requested only when it does not already hold that block, so a fetch that hits both buffers issues no request.
- R5: When both buffers need a load for one fetch, the current buffer's request is accepted first. The prefetch request is accepted in a later cycle in which `req_ready` is high.
- R6: Request tags come from one counter that starts at 0x80000000 after reset and grows by one for each accepted request (`req_valid` and `req_ready` both high).
- R7: `fetch_done` is high only while the current buffer holds the rounded address and has no request outstanding. After a miss it rises in the cycle after the matching response is presented. On a hit with no penalty it is high in the same cycle as `fetch_valid`.
- R8: A response retires a buffer only if `rsp_slot` is that buffer's number and `rsp_tag` equals its outstanding tag. Any other response is ignored, including the stale answer to a prefetch that was retargeted.
- R9: `pen_load` stores `pen_cycles`. The next active fetch is held for at least that many cycles, and the penalty is then cleared, so later fetches are not charged.
- R10: While `icache_on` and `cycle_acct_on` are both low, `fetch_done` follows `fetch_valid`, no request is raised, and neither buffer state nor the stored penalty changes.
- R11: After reset both buffers are empty, no request is raised, and the tag counter holds 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icache_on | input | 1 | Instruction cache enabled |
| cycle_acct_on | input | 1 | Cycle accounting enabled |
| fetch_valid | input | 1 | Fetch address presented; held until done |
| fetch_pc | input | 32 | Fetch byte address |
| fetch_done | output | 1 | Fetch may complete this cycle |
| pen_load | input | 1 | Store a branch penalty |
| pen_cycles | input | PEN_W | Penalty length in cycles |
| req_valid | output | 1 | Cache load request valid |
| req_ready | input | 1 | Cache accepts the request |
| req_addr | output | 32 | Block address to load |
| req_tag | output | 32 | Request tag |
| req_slot | output | 1 | Buffer being filled |
| rsp_valid | input | 1 | Cache response valid |
| rsp_tag | input | 32 | Tag of the response |
| rsp_slot | input | 1 | Buffer the response is for |

## Verification
The bench injects responses that carry the right tag for the wrong buffer, and the wrong tag for the right buffer, while a miss is outstanding. A design that compares only one of the two would release the fetch cycles too early. It also sends fetches that abandon a block while its prefetch is still in flight. If the stale answer retired the retargeted buffer, the fetch would finish before its own response arrived. A fetch that misses both buffers checks that the current block's request leaves before the next block's and that tags run on from 0x80000000 without gaps. A swapped order or a counter that also stepped on refused requests would show up in the logged request stream. Penalty and bypass cases check that the penalty is charged exactly once and survives a bypassed fetch, and that a bypassed fetch leaves both buffers where they were.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

    localparam int unsigned IFP_AW    = 32;
    localparam int unsigned IFP_TW    = 32;
    localparam int unsigned IFP_NSLOT = 2;

    typedef logic [IFP_AW-1:0] ifp_addr_t;
    typedef logic [IFP_TW-1:0] ifp_tag_t;

    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_QUEUED = 2'd1,
        SLOT_WAIT   = 2'd2
    } slot_st_e;

    typedef struct packed {
        logic      hold;
        ifp_addr_t base;
        slot_st_e  st;
        ifp_tag_t  tag;
    } slot_t;

    function automatic ifp_addr_t blk_floor(input ifp_addr_t a, input int unsigned blk);
        ifp_addr_t m;
        m = ifp_addr_t'(blk) - ifp_addr_t'(1);
        return a & ~m;
    endfunction

endpackage

// File: rtl/ifp_slot.sv
module ifp_slot import ifp_pkg::*; #(
    parameter logic ID = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  ifp_addr_t load_addr_i,
    input  logic      issue_i,
    input  ifp_tag_t  issue_tag_i,
    input  logic      rsp_valid_i,
    input  ifp_tag_t  rsp_tag_i,
    input  logic      rsp_slot_i,
    output slot_t     slot_o
);

    slot_t q;
    logic  retire;

    // a response only counts when both the buffer number and the tag agree
    assign retire = rsp_valid_i && (rsp_slot_i == ID) &&
                    (q.st == SLOT_WAIT) && (rsp_tag_i == q.tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            q.hold <= 1'b0;
            q.base <= '0;
            q.st   <= SLOT_EMPTY;
            q.tag  <= '0;
        end else if (load_i) begin
            q.hold <= 1'b1;
            q.base <= load_addr_i;
            q.st   <= SLOT_QUEUED;
        end else if (issue_i) begin
            q.st  <= SLOT_WAIT;
            q.tag <= issue_tag_i;
        end else if (retire) begin
            q.st <= SLOT_EMPTY;
        end
    end

    assign slot_o = q;

endmodule

// File: rtl/ifp_select.sv
module ifp_select import ifp_pkg::*; #(
    parameter int unsigned BLK_BYTES = 16
) (
    input  ifp_addr_t                pc,
    input  slot_t [IFP_NSLOT-1:0]    slot,
    output logic                     cur_id,
    output ifp_addr_t                cur_blk,
    output ifp_addr_t                pre_blk,
    output logic                     cur_miss,
    output logic                     pre_miss,
    output logic                     cur_ready
);

    logic [IFP_NSLOT-1:0] hit;
    logic                 pre_id;

    assign cur_blk = blk_floor(pc, BLK_BYTES);
    assign pre_blk = cur_blk + ifp_addr_t'(BLK_BYTES);

    for (genvar g = 0; g < IFP_NSLOT; g++) begin : g_hit
        assign hit[g] = slot[g].hold && (slot[g].base == cur_blk);
    end

    // buffer 0 wins ties and is the fallback
    assign cur_id    = !hit[0] && hit[1];
    assign pre_id    = !cur_id;
    assign cur_miss  = !hit[cur_id];
    assign pre_miss  = !(slot[pre_id].hold && (slot[pre_id].base == pre_blk));
    assign cur_ready = hit[cur_id] && (slot[cur_id].st == SLOT_EMPTY);

endmodule

// File: rtl/ifp_penalty.sv
module ifp_penalty #(
    parameter int unsigned PEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [PEN_W-1:0] cycles_i,
    input  logic             consume_i,
    output logic             zero_o
);

    logic [PEN_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load_i)
            left <= cycles_i;
        else if (consume_i && (left != '0))
            left <= left - 1'b1;
    end

    assign zero_o = (left == '0);

endmodule

// File: rtl/ifp_ctrl.sv
module ifp_ctrl import ifp_pkg::*; #(
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned PEN_W     = 4,
    parameter ifp_tag_t    TAG_INIT  = {1'b1, {(IFP_TW-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              icache_on,
    input  logic              cycle_acct_on,
    input  logic              fetch_valid,
    input  logic [IFP_AW-1:0] fetch_pc,
    output logic              fetch_done,
    input  logic              pen_load,
    input  logic [PEN_W-1:0]  pen_cycles,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [IFP_AW-1:0] req_addr,
    output logic [IFP_TW-1:0] req_tag,
    output logic              req_slot,
    input  logic              rsp_valid,
    input  logic [IFP_TW-1:0] rsp_tag,
    input  logic              rsp_slot
);

    logic                         bypass;
    logic                         active;
    slot_t     [IFP_NSLOT-1:0]    slot;
    logic                         cur_id;
    ifp_addr_t                    cur_blk;
    ifp_addr_t                    pre_blk;
    logic                         cur_miss;
    logic                         pre_miss;
    logic                         cur_ready;
    logic      [IFP_NSLOT-1:0]    load_v;
    ifp_addr_t [IFP_NSLOT-1:0]    load_a;
    logic      [IFP_NSLOT-1:0]    queued;
    logic      [IFP_NSLOT-1:0]    issue;
    logic                         first_q;
    logic                         pick;
    logic                         accept;
    logic                         pen_zero;
    ifp_tag_t                     tag_ctr;

    assign bypass = !icache_on && !cycle_acct_on;
    assign active = fetch_valid && !bypass;

    ifp_select #(.BLK_BYTES(BLK_BYTES)) u_sel (
        .pc        (fetch_pc),
        .slot      (slot),
        .cur_id    (cur_id),
        .cur_blk   (cur_blk),
        .pre_blk   (pre_blk),
        .cur_miss  (cur_miss),
        .pre_miss  (pre_miss),
        .cur_ready (cur_ready)
    );

    always_comb begin
        load_v          = '0;
        load_a          = '0;
        load_v[cur_id]  = active && cur_miss;
        load_a[cur_id]  = cur_blk;
        load_v[~cur_id] = active && pre_miss;
        load_a[~cur_id] = pre_blk;
    end

    for (genvar g = 0; g < IFP_NSLOT; g++) begin : g_slot
        // a buffer being retargeted this cycle holds back its request
        assign queued[g] = (slot[g].st == SLOT_QUEUED) && !load_v[g];
        assign issue[g]  = accept && (pick == 1'(g));

        ifp_slot #(.ID(1'(g))) u_slot (
            .clk         (clk),
            .rst         (rst),
            .load_i      (load_v[g]),
            .load_addr_i (load_a[g]),
            .issue_i     (issue[g]),
            .issue_tag_i (tag_ctr),
            .rsp_valid_i (rsp_valid),
            .rsp_tag_i   (rsp_tag),
            .rsp_slot_i  (rsp_slot),
            .slot_o      (slot[g])
        );
    end

    // the buffer that was current at the last fetch goes to the cache first
    always_ff @(posedge clk) begin
        if (rst)
            first_q <= 1'b0;
        else if (active)
            first_q <= cur_id;
    end

    assign pick      = queued[first_q] ? first_q : ~first_q;
    assign req_valid = !bypass && (|queued);
    assign accept    = req_valid && req_ready;
    assign req_addr  = slot[pick].base;
    assign req_tag   = tag_ctr;
    assign req_slot  = pick;

    always_ff @(posedge clk) begin
        if (rst)
            tag_ctr <= TAG_INIT;
        else if (accept)
            tag_ctr <= tag_ctr + 1'b1;
    end

    ifp_penalty #(.PEN_W(PEN_W)) u_pen (
        .clk       (clk),
        .rst       (rst),
        .load_i    (pen_load),
        .cycles_i  (pen_cycles),
        .consume_i (active),
        .zero_o    (pen_zero)
    );

    assign fetch_done = fetch_valid && (bypass || (pen_zero && cur_ready));

endmodule

// File: rtl/ifp_ctrl_chk.sv
module ifp_ctrl_chk import ifp_pkg::*; #(
    parameter int unsigned BLK_BYTES = 16,
    parameter ifp_tag_t    TAG_INIT  = {1'b1, {(IFP_TW-1){1'b0}}}
) (
    input logic              clk,
    input logic              rst,
    input logic              bypass,
    input logic              fetch_valid,
    input logic              fetch_done,
    input logic              pen_zero,
    input logic              req_valid,
    input logic              req_ready,
    input logic [IFP_AW-1:0] req_addr,
    input logic [IFP_TW-1:0] req_tag
);

    localparam ifp_addr_t LOW_MASK = ifp_addr_t'(BLK_BYTES) - ifp_addr_t'(1);

    logic     seen;
    ifp_tag_t last_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen     <= 1'b0;
            last_tag <= '0;
        end else if (req_valid && req_ready) begin
            seen     <= 1'b1;
            last_tag <= req_tag;
        end
    end

    // R1
    req_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_addr & LOW_MASK) == '0));

    // R6
    first_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !seen) |-> (req_tag == TAG_INIT));

    // R6
    tag_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && seen) |-> (req_tag == last_tag + 1'b1));

    // R9
    pen_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_done && !bypass) |-> pen_zero);

    // R10
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |-> !req_valid);

    // R10
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (bypass && fetch_valid) |-> fetch_done);

    // R11
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !req_valid);

endmodule

bind ifp_ctrl ifp_ctrl_chk #(
    .BLK_BYTES (BLK_BYTES),
    .TAG_INIT  (TAG_INIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bypass      (bypass),
    .fetch_valid (fetch_valid),
    .fetch_done  (fetch_done),
    .pen_zero    (pen_zero),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_tag     (req_tag)
);

// File: tb/sim_ifp_ctrl.sv
module sim_ifp_ctrl;

    localparam int unsigned BLK   = 16;
    localparam int unsigned LAT   = 4;
    localparam int unsigned PEN_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              icache_on = 1'b1;
    logic              cycle_acct_on = 1'b1;
    logic              fetch_valid = 1'b0;
    logic [31:0]       fetch_pc = '0;
    logic              fetch_done;
    logic              pen_load = 1'b0;
    logic [PEN_W-1:0]  pen_cycles = '0;
    logic              req_valid;
    logic              req_ready = 1'b1;
    logic [31:0]       req_addr;
    logic [31:0]       req_tag;
    logic              req_slot;
    logic              rsp_valid;
    logic [31:0]       rsp_tag;
    logic              rsp_slot;

    int n_chk  = 0;
    int n_fail = 0;
    logic rnd_rdy = 1'b0;

    always #5 clk = ~clk;

    ifp_ctrl #(.BLK_BYTES(BLK), .PEN_W(PEN_W)) u0 (
        .clk(clk), .rst(rst), .icache_on(icache_on), .cycle_acct_on(cycle_acct_on),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_done(fetch_done),
        .pen_load(pen_load), .pen_cycles(pen_cycles),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_tag(req_tag), .req_slot(req_slot),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_slot(rsp_slot)
    );

    // cache model: fixed latency pipe plus an injection port
    logic [LAT-1:0] pv = '0;
    logic [31:0]    pt [LAT];
    logic           ps [LAT];
    logic           inj_v = 1'b0;
    logic [31:0]    inj_t = '0;
    logic           inj_s = 1'b0;

    always @(posedge clk) begin
        pv    <= {pv[LAT-2:0], req_valid && req_ready};
        pt[0] <= req_tag;
        ps[0] <= req_slot;
        for (int i = 1; i < LAT; i++) begin
            pt[i] <= pt[i-1];
            ps[i] <= ps[i-1];
        end
    end

    assign rsp_valid = pv[LAT-1] | inj_v;
    assign rsp_tag   = pv[LAT-1] ? pt[LAT-1] : inj_t;
    assign rsp_slot  = pv[LAT-1] ? ps[LAT-1] : inj_s;

    always @(negedge clk) req_ready = rnd_rdy ? (($urandom % 4) != 0) : 1'b1;

    // request log and response watch
    logic [31:0] ob_a [1024];
    logic [31:0] ob_t [1024];
    logic        ob_s [1024];
    int          ob_n = 0;
    logic [31:0] want_tag = '0;
    logic        want_slot = 1'b0;
    logic        got_rsp = 1'b0;

    always @(posedge clk) begin
        if (req_valid && req_ready && ob_n < 1024) begin
            ob_a[ob_n] = req_addr;
            ob_t[ob_n] = req_tag;
            ob_s[ob_n] = req_slot;
            ob_n = ob_n + 1;
        end
        if (pv[LAT-1] && rsp_tag == want_tag && rsp_slot == want_slot)
            got_rsp = 1'b1;
    end

    // reference model built from the requirements
    logic [31:0] m_base [2];
    logic        m_hold [2];
    logic [31:0] m_tag = 32'h8000_0000;
    int          e_n;
    logic [31:0] e_a [2];
    logic [31:0] e_t [2];
    logic        e_s [2];
    logic        e_curmiss;

    task automatic model_step(input logic [31:0] pc);
        logic [31:0] b;
        logic [31:0] nb;
        logic        c;
        logic        p;
        b  = pc & ~(32'(BLK) - 32'd1);
        nb = b + 32'(BLK);
        c  = (m_hold[0] && m_base[0] == b) ? 1'b0 :
             (m_hold[1] && m_base[1] == b) ? 1'b1 : 1'b0;
        p  = ~c;
        e_n = 0;
        e_curmiss = !(m_hold[c] && m_base[c] == b);
        if (e_curmiss) begin
            e_a[e_n] = b; e_s[e_n] = c; e_t[e_n] = m_tag;
            m_tag++; e_n++; m_base[c] = b; m_hold[c] = 1'b1;
        end
        if (!(m_hold[p] && m_base[p] == nb)) begin
            e_a[e_n] = nb; e_s[e_n] = p; e_t[e_n] = m_tag;
            m_tag++; e_n++; m_base[p] = nb; m_hold[p] = 1'b1;
        end
    endtask

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] pc, output int n);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_pc    = pc;
        #1;
        n = 0;
        while (!fetch_done && n < 300) begin
            @(posedge clk);
            #1;
            n++;
        end
        if (!fetch_done) chk("R7", 64'd0, 64'd1, "fetch never completed");
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (req_valid) @(negedge clk);
        repeat (LAT + 3) @(negedge clk);
    endtask

    task automatic run_fetch(input logic [31:0] pc, input int exp_n, input string rq);
        int s;
        int n;
        s = ob_n;
        model_step(pc);
        want_tag  = e_t[0];
        want_slot = e_s[0];
        got_rsp   = 1'b0;
        do_fetch(pc, n);
        if (exp_n >= 0) chk(rq, 64'(n), 64'(exp_n), "hold cycles");
        if (e_curmiss) chk("R8", 64'(got_rsp), 64'd1, "done before own response");
        drain();
        chk("R3", 64'(ob_n - s), 64'(e_n), "request count");
        for (int i = 0; i < e_n; i++) begin
            chk("R1", 64'(ob_a[s+i]), 64'(e_a[i]), "request address");
            chk("R5", 64'(ob_s[s+i]), 64'(e_s[i]), "request buffer order");
            chk("R6", 64'(ob_t[s+i]), 64'(e_t[i]), "request tag");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("R7", 64'd0, 64'd1, "watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        int s;
        m_hold[0] = 1'b0; m_hold[1] = 1'b0;
        m_base[0] = '0;   m_base[1] = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: idle after reset
        chk("R11", 64'(req_valid), 64'd0, "request after reset");
        chk("R11", 64'(fetch_done), 64'd0, "done without fetch");

        // R7 R8: cold miss with bogus responses injected while waiting
        fork
            run_fetch(32'h0000_1004, LAT + 2, "R7");
            begin
                repeat (3) @(negedge clk);
                inj_v = 1'b1; inj_s = 1'b1; inj_t = 32'h8000_0000;
                @(negedge clk);
                inj_s = 1'b0; inj_t = 32'h8000_0005;
                @(negedge clk);
                inj_v = 1'b0;
            end
        join
        chk("R1", 64'(ob_a[0]), 64'h1000, "first block address");
        chk("R2", 64'(ob_s[0]), 64'd0, "default buffer on cold miss");
        chk("R6", 64'(ob_t[0]), 64'h8000_0000, "first tag");
        chk("R4", 64'(ob_a[1]), 64'h1010, "prefetch block address");
        chk("R4", 64'(ob_s[1]), 64'd1, "prefetch buffer");

        // R2 R4: hit in buffer 1, buffer 0 refilled with the next block
        run_fetch(32'h0000_101C, 0, "R2");
        chk("R4", 64'(ob_a[2]), 64'h1020, "ping-pong refill address");
        chk("R4", 64'(ob_s[2]), 64'd0, "ping-pong refill buffer");

        // R9: penalty charged once
        @(negedge clk); pen_load = 1'b1; pen_cycles = 4'd3;
        @(negedge clk); pen_load = 1'b0;
        run_fetch(32'h0000_1020, 3, "R9");
        run_fetch(32'h0000_1024, 0, "R9");

        // R10: bypass leaves buffers and penalty alone
        @(negedge clk); pen_load = 1'b1; pen_cycles = 4'd2;
        @(negedge clk); pen_load = 1'b0;
        icache_on = 1'b0; cycle_acct_on = 1'b0;
        s = ob_n;
        do_fetch(32'h0000_9000, n);
        chk("R10", 64'(n), 64'd0, "bypass hold cycles");
        repeat (8) @(negedge clk);
        chk("R10", 64'(ob_n - s), 64'd0, "requests in bypass");
        icache_on = 1'b1;
        run_fetch(32'h0000_1028, 2, "R10");

        // R2: neither buffer matches, buffer 0 is chosen
        icache_on = 1'b0; cycle_acct_on = 1'b1;
        run_fetch(32'h0000_2000, LAT + 2, "R2");
        icache_on = 1'b1;

        // random walk with back-pressure, redirects and stale responses
        rnd_rdy = 1'b1;
        for (int k = 0; k < 150; k++) begin
            logic [31:0] pc;
            pc = 32'h4000 + 32'(($urandom % 8) * BLK) + 32'($urandom % BLK);
            run_fetch(pc, -1, "R7");
        end
        rnd_rdy = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule